// File: doc/BRIEF.md
# Dual-Mode FM0 / Manchester Line Encoder

This block turns a serial data stream into a line-coded waveform for a short-range radio link. Each data bit is sent as two half-bit symbols, first A and then B. The block runs on a clock at twice the bit rate, so each clock cycle carries one half-bit. A mode input picks one of two codes for each bit. In FM0 (bi-phase space) the level always changes at every bit edge and also changes mid-bit for a zero. In Manchester the level is the data bit in the first half and its inverse in the second half.

Both codes come from one shared datapath: one output register, one internal half-bit phase flag and one XOR stage. A select network only decides what is fed to the XOR. FM0 inverts the stored level. Manchester combines the sampled bit with the phase. The data and mode inputs are taken once per bit, on the first half-bit cycle. When enable is low, the encoder freezes in place, including partway through a bit.

Top module: `dual_line_encoder`

## Requirements
- R1: While reset is low at a clock edge, line_out becomes 0 and the half-bit phase returns to "first half". After reset is released, the first FM0 bit therefore starts with A = 1.
- R2: In FM0 mode (mode_sel = 0), a data bit of 0 gives B = not A.
- R3: In FM0 mode, a data bit of 1 gives B = A.
- R4: In FM0 mode, A of each bit is the inverse of the level that was on the line just before it. This covers B of the previous bit, or the reset level.
- R5: In Manchester mode (mode_sel = 1), A equals the data bit and B equals its inverse, so every bit has a mid-bit transition.
- R6: din and mode_sel are sampled only on the first half-bit cycle of a bit. Changes to them during the B half do not affect B. A mode change therefore takes effect at the next bit boundary.
- R7: While en is low, line_out and the half-bit phase hold their values, even in the middle of a bit.
- R8: The first enabled cycle after reset is the A half of a bit. Each enabled cycle then advances one half-bit.
- R9: line_out is registered: the half-bit sampled at a clock edge appears after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance one half-bit when high, hold when low |
| din | input | 1 | Serial data bit, sampled on the first half-bit cycle |
| mode_sel | input | 1 | 0 = FM0, 1 = Manchester; sampled with din |
| line_out | output | 1 | Registered line-coded half-bit symbol |

## Verification
Embedded assertions check several rules on every cycle. They cover the phase toggling and freezing with enable, the inversion at each FM0 bit edge, the mid-bit behaviour of FM0 for zeros and ones, the Manchester first-half value and its mid-bit flip, and the fact that the sampled bit and mode stay constant outside the first half. Other behaviour can only be shown by the bench scenarios. These include the full A/B waveform for long data patterns, switches between modes at bit boundaries, stalls in the middle of a bit, glitches on the inputs during the B half, and the position of the first bit after reset. To check these, the bench compares every half-bit against a queue of levels predicted from the coding rules.

// File: rtl/line_enc_pkg.sv
// Shared types for the dual-mode line encoder.
package line_enc_pkg;
    // Code chosen for one bit period; the encoding matches the mode_sel pin.
    typedef enum logic {
        CODE_FM0   = 1'b0,
        CODE_MANCH = 1'b1
    } code_e;
endpackage

// File: rtl/halfbit_phase.sv
// Half-bit phase tracker.
// Does: toggles a flag on every enabled cycle. 0 marks the A half, 1 marks the B half.
// Assumes: the clock runs at twice the bit rate; reset is synchronous and active low.
module halfbit_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic second_half,
    output logic bit_start
);
    // Purpose: flag a cycle that opens a new bit period.
    always_comb begin
        bit_start = en & ~second_half;
    end

    // Purpose: advance the phase on each enabled cycle and freeze it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_half <= 1'b0;
        end else if (en) begin
            second_half <= ~second_half;
        end
    end

    assert_phase_reset_R1: assert property (@(posedge clk) !rst_n |=> !second_half);
    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(second_half));
    assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> second_half != $past(second_half));
endmodule

// File: rtl/bit_capture.sv
// Per-bit input capture.
// Does: latches the data bit and the code selection when a bit period opens.
// Assumes: load is high for exactly one enabled cycle per bit, the A half.
module bit_capture
    import line_enc_pkg::*;
#(
    parameter logic  RST_BIT  = 1'b0,
    parameter code_e RST_MODE = CODE_FM0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  din,
    input  code_e mode_in,
    output logic  bit_q,
    output code_e mode_q
);
    // Purpose: hold the bit and code for the B half of the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= RST_BIT;
            mode_q <= RST_MODE;
        end else if (load) begin
            bit_q  <= din;
            mode_q <= mode_in;
        end
    end

    assert_sample_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(bit_q) && $stable(mode_q)));
endmodule

// File: rtl/shared_xor_coder.sv
// Shared XOR coder.
// Does: computes the next line level as base XOR flip through one XOR gate and
//       one register for both codes. FM0 uses base = the stored level and flips it
//       at a bit edge, and mid-bit only for a zero. Manchester uses base = the data
//       bit and flip = the phase.
// Assumes: in the A half the live inputs are used, because the captured copies
//          load on that same edge; in the B half the captured copies are used.
module shared_xor_coder
    import line_enc_pkg::*;
#(
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  second_half,
    input  logic  din,
    input  code_e mode_in,
    input  logic  bit_q,
    input  code_e mode_q,
    output logic  level
);
    code_e cur_mode;
    logic  cur_bit;
    logic  base;
    logic  flip;
    logic  level_nxt;

    // Purpose: choose the bit and code that apply to this half-bit.
    always_comb begin
        cur_mode = second_half ? mode_q : mode_in;
        cur_bit  = second_half ? bit_q  : din;
    end

    // Purpose: steer the operands of the single shared XOR according to the code.
    always_comb begin
        if (cur_mode == CODE_FM0) begin
            base = level;
            flip = second_half ? ~cur_bit : 1'b1;
        end else begin
            base = cur_bit;
            flip = second_half;
        end
        level_nxt = base ^ flip;
    end

    // Purpose: register the line level and hold it while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= INIT_LEVEL;
        end else if (en) begin
            level <= level_nxt;
        end
    end

    assert_level_reset_R1: assert property (@(posedge clk) !rst_n |=> level == INIT_LEVEL);
    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(level));
    assert_fm0_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !second_half && mode_in == CODE_FM0) |=> level != $past(level));
    assert_fm0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && second_half && mode_q == CODE_FM0 && !bit_q) |=> level != $past(level));
    assert_fm0_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && second_half && mode_q == CODE_FM0 && bit_q) |=> $stable(level));
    assert_manch_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !second_half && mode_in == CODE_MANCH) |=> level == $past(din));
    assert_manch_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && second_half && mode_q == CODE_MANCH) |=> level != $past(level));
endmodule

// File: rtl/dual_line_encoder.sv
// Dual-mode FM0 / Manchester line encoder, top level.
// Does: connects the phase tracker, the per-bit capture and the shared XOR coder.
// Assumes: clk runs at twice the bit rate; rst_n is synchronous and active low;
//          mode_sel 0 selects FM0 and 1 selects Manchester.
module dual_line_encoder
    import line_enc_pkg::*;
#(
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    input  logic mode_sel,
    output logic line_out
);
    code_e mode_live;
    code_e mode_held;
    logic  second_half;
    logic  bit_start;
    logic  bit_held;

    // Purpose: give the raw mode pin its enumerated meaning.
    always_comb begin
        mode_live = code_e'(mode_sel);
    end

    halfbit_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .second_half (second_half),
        .bit_start   (bit_start)
    );

    bit_capture #(
        .RST_BIT  (1'b0),
        .RST_MODE (CODE_FM0)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bit_start),
        .din     (din),
        .mode_in (mode_live),
        .bit_q   (bit_held),
        .mode_q  (mode_held)
    );

    shared_xor_coder #(
        .INIT_LEVEL (INIT_LEVEL)
    ) u_coder (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .second_half (second_half),
        .din         (din),
        .mode_in     (mode_live),
        .bit_q       (bit_held),
        .mode_q      (mode_held),
        .level       (line_out)
    );
endmodule

// File: tb/dual_line_encoder_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks predict each half-bit level and queue it; the
// monitor pops one entry per falling edge and compares it with line_out.
module dual_line_encoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic din = 1'b0;
    logic mode_sel = 1'b0;
    logic line_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string req_q[$];
    logic  model_lvl = 1'b0;

    always #2.5 clk = ~clk;

    dual_line_encoder uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .din      (din),
        .mode_sel (mode_sel),
        .line_out (line_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: line_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic lvl, input string req);
        exp_q.push_back(lvl);
        req_q.push_back(req);
    endtask

    // Monitor: compare one queued half-bit per falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            check(line_out, exp_q.pop_front(), req_q.pop_front());
        end
    end

    // Send one bit. stall inserts disabled cycles between A and B (R7).
    // glitch flips din and mode_sel during the B half (R6).
    task automatic send_bit(input logic d, input logic m, input int stall, input bit glitch);
        logic a;
        logic b;
        string ra;
        string rb;
        if (m == 1'b0) begin
            a  = ~model_lvl;
            b  = d ? a : ~a;
            ra = "R4";
            rb = d ? "R3" : "R2";
        end else begin
            a  = d;
            b  = ~d;
            ra = "R5";
            rb = "R5";
        end
        @(negedge clk);
        en = 1'b1; din = d; mode_sel = m;
        @(posedge clk); #1;
        push(a, ra);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            en = 1'b0;
            @(posedge clk); #1;
            push(a, "R7");
        end
        @(negedge clk);
        en = 1'b1;
        if (glitch) begin
            din = ~d; mode_sel = ~m; rb = "R6";
        end
        @(posedge clk); #1;
        push(b, rb);
        model_lvl = b;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en = 1'b0; din = ~din;
            @(posedge clk); #1;
            push(model_lvl, req);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1; din = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        check(line_out, 1'b0, "R1");
        rst_n = 1'b1; en = 1'b0;
        model_lvl = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        // R8: disabled cycles after reset keep the line low, then the first enabled cycle is A.
        idle(3, "R8");
        send_bit(1'b1, 1'b0, 0, 1'b0);  // FM0 first bit: A = 1 (R1, R4)
        send_bit(1'b0, 1'b0, 0, 1'b0);
        send_bit(1'b0, 1'b0, 0, 1'b0);
        send_bit(1'b1, 1'b0, 0, 1'b0);
        send_bit(1'b1, 1'b0, 0, 1'b0);
        // Manchester pattern
        send_bit(1'b1, 1'b1, 0, 1'b0);
        send_bit(1'b0, 1'b1, 0, 1'b0);
        send_bit(1'b0, 1'b1, 0, 1'b0);
        send_bit(1'b1, 1'b1, 0, 1'b0);
        // Switch back to FM0 at a bit boundary (R6, R4)
        send_bit(1'b0, 1'b0, 0, 1'b0);
        // Stalls in the middle of a bit (R7)
        send_bit(1'b1, 1'b0, 2, 1'b0);
        send_bit(1'b0, 1'b1, 3, 1'b0);
        idle(2, "R7");
        // Input changes during the B half are ignored (R6)
        send_bit(1'b0, 1'b0, 0, 1'b1);
        send_bit(1'b1, 1'b0, 0, 1'b1);
        send_bit(1'b1, 1'b1, 0, 1'b1);
        send_bit(1'b0, 1'b1, 0, 1'b1);
        // Pseudo-random data in both codes; registered output (R9)
        for (int k = 0; k < 40; k++) begin
            send_bit(1'((k * 7 + 3) % 5 > 1), 1'((k / 5) % 2), k % 3 == 0 ? 1 : 0, 1'(k % 4 == 2));
        end
        // Reset in the middle of a run, then restart (R1, R8)
        repeat (2) @(negedge clk);
        do_reset();
        send_bit(1'b0, 1'b0, 0, 1'b0);
        send_bit(1'b1, 1'b1, 0, 1'b0);
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d half-bits left unchecked, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule